// File: doc/BRIEF.md
# Comparator Control and Interrupt Logic

This block is the digital wrapper that sits beside an analog voltage comparator. It holds two 8-bit registers on a simple register bus: a mux register at address 0 and a status register at address 1. From these registers it drives the select lines that choose the comparator's positive and negative inputs, the comparator power-down line, an input-capture enable and a 3-bit trigger select. The analog comparator, the reference and the ADC sit outside the block and appear only as pins.

The raw comparator output passes through a synchronizer chain and is readable as a status bit. A two-state level tracker, with states `LVL_LOW` and `LVL_HIGH`, follows the synchronized level. In `LVL_LOW`, a synchronized 1 is a rising event and causes the transition `LVL_LOW -> LVL_HIGH`. In `LVL_HIGH`, a synchronized 0 is a falling event and causes the transition `LVL_HIGH -> LVL_LOW`. Otherwise the tracker stays in its state.

An event that matches the selected mode sets a sticky interrupt flag. The flag raises an interrupt request when interrupts are enabled both locally and globally. The flag clears when the CPU acknowledges the interrupt, or when software writes 1 to the flag bit.

Top module: `cmp_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, and `irq_req`, `pwr_down`, `pos_use_ref` and `neg_use_mux` are 0.
- R2: In the mux register (address 0), bit 6 (mux enable) and bits 2..0 (trigger select, driven on `trig_sel`) can be read and written. Bits 7 and 5..3 read as 0.
- R3: `neg_use_mux` is 1 and `neg_chan` equals `adc_chan` only while mux enable is 1 and `adc_on` is 0. Otherwise `neg_use_mux` is 0 and `neg_chan` is 0.
- R4: Status bit 6 (reference select) drives `pos_use_ref`.
- R5: Status bit 5 is read-only. It shows `cmp_raw` after two clock edges.
- R6: The mode field is status bits 1..0. Encoding 00 sets the flag on either edge, 01 sets it on no event, 10 sets it on a falling edge and 11 sets it on a rising edge. The flag (status bit 4) is set on the third clock edge after `cmp_raw` changes.
- R7: `irq_req` is 1 exactly when the flag, the interrupt enable (status bit 3) and `gie` are all 1.
- R8: A one-cycle pulse on `irq_ack` clears the flag.
- R9: Writing status with bit 4 at 1 clears the flag. Writing it with bit 4 at 0 leaves the flag unchanged.
- R10: If a matching event and a clear (acknowledge or write of 1) happen in the same cycle, the flag ends up set.
- R11: While status bit 7 (disable) is 1, `pwr_down` is 1, the output bit holds its value and no event sets the flag. After the disable bit is cleared, a pending change produces its event.
- R12: Status bits 7, 6, 3, 2 and 1..0 can be read and written. Bit 2 drives `cap_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address (0 = mux, 1 = status) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is 0 when low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cmp_raw | input | 1 | Raw comparator output |
| adc_on | input | 1 | ADC is enabled |
| adc_chan | input | 3 | ADC channel code |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge for this vector |
| pos_use_ref | output | 1 | Positive input taken from the internal reference |
| neg_use_mux | output | 1 | Negative input taken from the ADC channel mux |
| neg_chan | output | 3 | Channel for the negative input |
| pwr_down | output | 1 | Comparator power-down |
| cap_en | output | 1 | Input-capture enable |
| trig_sel | output | 3 | Trigger select |
| irq_req | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle: a synchronized edge event that sets the flag, and a clear of that flag by acknowledge or by a write of 1. The bench provokes the collision by changing `cmp_raw` and then counting two clock edges. It then pulses `irq_ack`, or issues a clearing write, in exactly the cycle before the edge that records the event. After that edge it reads the flag and expects it to be set. It also checks that the same clears, given away from any event, do empty the flag.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MD_TOGGLE = 2'b00,
        MD_RSVD   = 2'b01,
        MD_FALL   = 2'b10,
        MD_RISE   = 2'b11
    } mode_e;

    typedef enum logic [0:0] {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // status register bit positions
    localparam int ST_DIS  = 7;
    localparam int ST_REF  = 6;
    localparam int ST_OUT  = 5;
    localparam int ST_FLAG = 4;
    localparam int ST_IE   = 3;
    localparam int ST_CAP  = 2;
    // mux register bit positions
    localparam int MX_EN   = 6;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s;
            always_ff @(posedge clk) begin
                if (!rst_n)     s <= 1'b0;
                else if (!hold) s <= d;
            end
            assign q = s;
        end else begin : g_chain
            logic [STAGES-1:0] s;
            always_ff @(posedge clk) begin
                if (!rst_n)     s <= '0;
                else if (!hold) s <= {s[STAGES-2:0], d};
            end
            assign q = s[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cmp_edge_fsm.sv
module cmp_edge_fsm
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] mode_i,
    output logic       evt_o
);
    lvl_e state, state_nx;
    logic rise, fall;

    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_LOW:  if (sync_i)  state_nx = LVL_HIGH;
            LVL_HIGH: if (!sync_i) state_nx = LVL_LOW;
            default:  state_nx = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LVL_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state)
            LVL_LOW:  rise = sync_i;
            LVL_HIGH: fall = !sync_i;
            default: ;
        endcase
        unique case (mode_e'(mode_i))
            MD_TOGGLE: evt_o = rise | fall;
            MD_RSVD:   evt_o = 1'b0;
            MD_FALL:   evt_o = fall;
            MD_RISE:   evt_o = rise;
            default:   evt_o = 1'b0;
        endcase
    end

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_RSVD) |-> !evt_o); // R6
    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && mode_i == MD_RISE) |=> (state == LVL_HIGH)); // R6
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              out_i,
    input  logic              evt_i,
    input  logic              ack_i,
    output logic              dis_o,
    output logic              ref_o,
    output logic              flag_o,
    output logic              ie_o,
    output logic              cap_o,
    output logic [1:0]        mode_o,
    output logic              mux_en_o,
    output logic [2:0]        trig_o
);
    localparam logic [ADDR_W-1:0] A_MUX  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    logic wr_mux, wr_stat, clr;
    assign wr_mux  = wr && (addr == A_MUX);
    assign wr_stat = wr && (addr == A_STAT);
    assign clr     = ack_i || (wr_stat && wdata[ST_FLAG]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_en_o <= 1'b0;
            trig_o   <= '0;
        end else if (wr_mux) begin
            mux_en_o <= wdata[MX_EN];
            trig_o   <= wdata[2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_o  <= 1'b0;
            ref_o  <= 1'b0;
            ie_o   <= 1'b0;
            cap_o  <= 1'b0;
            mode_o <= 2'b00;
        end else if (wr_stat) begin
            dis_o  <= wdata[ST_DIS];
            ref_o  <= wdata[ST_REF];
            ie_o   <= wdata[ST_IE];
            cap_o  <= wdata[ST_CAP];
            mode_o <= wdata[1:0];
        end
    end

    // set has priority over either clear path
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (evt_i) flag_o <= 1'b1;
        else if (clr)   flag_o <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == A_STAT)
                rdata = {dis_o, ref_o, out_i, flag_o, ie_o, cap_o, mode_o};
            else
                rdata = {1'b0, mux_en_o, 3'b000, trig_o};
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_o); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt_i) |=> !flag_o); // R8
    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata[ST_FLAG] && flag_o && !ack_i) |=> flag_o); // R9
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
    import cmp_pkg::*;
#(
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_raw,
    input  logic              adc_on,
    input  logic [2:0]        adc_chan,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              pos_use_ref,
    output logic              neg_use_mux,
    output logic [2:0]        neg_chan,
    output logic              pwr_down,
    output logic              cap_en,
    output logic [2:0]        trig_sel,
    output logic              irq_req
);
    logic       sync_out, evt, flag, ie, mux_en;
    logic [1:0] mode;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .hold(pwr_down), .d(cmp_raw), .q(sync_out)
    );

    cmp_edge_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_out), .mode_i(mode), .evt_o(evt)
    );

    cmp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .out_i(sync_out), .evt_i(evt),
        .ack_i(irq_ack), .dis_o(pwr_down), .ref_o(pos_use_ref), .flag_o(flag),
        .ie_o(ie), .cap_o(cap_en), .mode_o(mode), .mux_en_o(mux_en),
        .trig_o(trig_sel)
    );

    assign neg_use_mux = mux_en && !adc_on;
    assign neg_chan    = neg_use_mux ? adc_chan : 3'b000;
    assign irq_req     = flag && ie && gie;

    AST_DIS_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) && pwr_down |-> !evt); // R11
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(sync_out)); // R11
endmodule

// File: tb/cmp_ctrl_test.sv
module cmp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       cmp_raw = 1'b0, adc_on = 1'b0, gie = 1'b0, irq_ack = 1'b0;
    logic [2:0] adc_chan = '0, neg_chan, trig_sel;
    logic       pos_use_ref, neg_use_mux, pwr_down, cap_en, irq_req;

    int checks = 0, fails = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    cmp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_raw(cmp_raw), .adc_on(adc_on), .adc_chan(adc_chan), .gie(gie),
        .irq_ack(irq_ack), .pos_use_ref(pos_use_ref), .neg_use_mux(neg_use_mux),
        .neg_chan(neg_chan), .pwr_down(pwr_down), .cap_en(cap_en),
        .trig_sel(trig_sel), .irq_req(irq_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd(0, rv); chk("R1 mux reg", rv, 8'h00);
        rd(1, rv); chk("R1 status reg", rv, 8'h00);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 pos_use_ref", pos_use_ref, 0);
        chk("R1 neg_use_mux", neg_use_mux, 0);
    endtask

    task automatic t_muxreg;
        wr(0, 8'hFF);
        rd(0, rv); chk("R2 readback", rv, 8'h47);
        chk("R2 trig_sel", trig_sel, 7);
        wr(0, 8'h00);
        rd(0, rv); chk("R2 cleared", rv, 8'h00);
    endtask

    task automatic t_status_rw;
        wr(1, 8'h6F);
        rd(1, rv); chk("R12 status readback, out bit read-only R5", rv, 8'h4F);
        chk("R4 pos_use_ref set", pos_use_ref, 1);
        chk("R12 cap_en", cap_en, 1);
        wr(1, 8'h00);
        chk("R4 pos_use_ref clear", pos_use_ref, 0);
        rd(1, rv); chk("R12 status cleared", rv, 8'h00);
    endtask

    task automatic t_negsel;
        wr(0, 8'h40); adc_chan = 3'd5; adc_on = 1'b0; #0.5;
        chk("R3 mux chosen", neg_use_mux, 1);
        chk("R3 channel", neg_chan, 5);
        adc_on = 1'b1; #0.5;
        chk("R3 adc on blocks mux", neg_use_mux, 0);
        chk("R3 channel zero", neg_chan, 0);
        wr(0, 8'h00); adc_on = 1'b0; #0.5;
        chk("R3 mux enable off", neg_use_mux, 0);
    endtask

    task automatic t_sync;
        cmp_raw = 1'b1;
        step(1);
        rd(1, rv); chk("R5 out after one edge", rv[5], 0);
        step(1);
        rd(1, rv); chk("R5 out after two edges", rv[5], 1);
        cmp_raw = 1'b0; step(4);
        rd(1, rv); chk("R5 out follows low", rv[5], 0);
    endtask

    task automatic t_mode(input logic [1:0] md, input logic er, input logic ef);
        cmp_raw = 1'b0; step(4);
        wr(1, {6'b000100, md});
        cmp_raw = 1'b1; step(3);
        rd(1, rv); chk($sformatf("R6 mode %0d rising", md), rv[4], er);
        wr(1, {6'b000100, md});
        cmp_raw = 1'b0; step(3);
        rd(1, rv); chk($sformatf("R6 mode %0d falling", md), rv[4], ef);
        wr(1, {6'b000100, md});
    endtask

    task automatic t_irq;
        wr(1, 8'h0B);
        cmp_raw = 1'b1; step(3);
        gie = 1'b0; #0.5; chk("R7 gie low masks", irq_req, 0);
        gie = 1'b1; #0.5; chk("R7 request raised", irq_req, 1);
        wr(1, 8'h03);
        chk("R7 ie low masks", irq_req, 0);
        rd(1, rv); chk("R9 write zero keeps flag", rv[4], 1);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        rd(1, rv); chk("R8 ack clears flag", rv[4], 0);
        cmp_raw = 1'b0; step(4);
        cmp_raw = 1'b1; step(3);
        rd(1, rv); chk("R9 flag set again", rv[4], 1);
        wr(1, 8'h13);
        rd(1, rv); chk("R9 write one clears", rv[4], 0);
        cmp_raw = 1'b0; step(4);
    endtask

    task automatic t_setwins;
        wr(1, 8'h18);
        cmp_raw = 1'b1; step(2);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        rd(1, rv); chk("R10 event beats ack", rv[4], 1);
        cmp_raw = 1'b0; step(2);
        wr(1, 8'h18);
        rd(1, rv); chk("R10 event beats write one", rv[4], 1);
        wr(1, 8'h10);
        rd(1, rv); chk("R10 later write one clears", rv[4], 0);
    endtask

    task automatic t_disable;
        wr(1, 8'h90);
        chk("R11 pwr_down", pwr_down, 1);
        cmp_raw = 1'b1; step(4);
        rd(1, rv);
        chk("R11 out held", rv[5], 0);
        chk("R11 no flag", rv[4], 0);
        wr(1, 8'h00);
        chk("R11 pwr_down off", pwr_down, 0);
        step(4);
        rd(1, rv);
        chk("R11 resume out", rv[5], 1);
        chk("R11 resume event", rv[4], 1);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_muxreg();
        t_status_rw();
        t_negsel();
        t_sync();
        t_mode(2'b00, 1'b1, 1'b1);
        t_mode(2'b01, 1'b0, 1'b0);
        t_mode(2'b10, 1'b0, 1'b1);
        t_mode(2'b11, 1'b1, 1'b0);
        t_irq();
        t_setwins();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule